// File: doc/BRIEF.md
# Half-Pulse-Safe Clock Source Switch

This block routes one of two unrelated clock sources to a single clock output, chosen by a level select. A fast source (nominally 36.864 MHz) and a slow source (nominally 33.8688 MHz) each have their own enable path. When the select changes, the path being left is shut off in its own clock domain first, so the output parks low. Only after that does the incoming path start in its own domain. Because of this ordering the output never shows a high or low pulse cut shorter than a half period.

An output-enable takes the same orderly route to a parked-low output. This gives a power-down state with no runt pulse, and raising the enable again restarts the selected source under the same rule. Each path clears at once on an active-low reset. Each path leaves reset on its own falling clock edges.

Top module: `hpsafe_clk_switch`

## Requirements
- R1: While `rst_ni` is low, `clk_o` is low and both paths are disabled. After release, the selected source starts under the rule of R5.
- R2: With `sel_fast_i` = 1 and `oe_i` = 1 in steady state, `clk_o` equals `clk_fast_i`.
- R3: With `sel_fast_i` = 0 and `oe_i` = 1 in steady state, `clk_o` equals `clk_slow_i`.
- R4: After the select changes, `clk_o` keeps following the outgoing source until that source's second falling edge after the change. It is low from that edge on.
- R5: The incoming source is enabled only on the second of its own falling edges seen after the outgoing path went idle. From then on its pulses pass through, and the two paths are never enabled together.
- R6: No high or low pulse on `clk_o` is shorter than the half period of the faster source.
- R7: With `oe_i` = 0, `clk_o` parks low by the same two-falling-edge rule and stays low. With `oe_i` = 1 again, the selected source restarts as in R5.
- R8: If the select toggles again before a changeover ends, the switch settles on the currently selected source, still obeying R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Fast source clock, chosen when select is 1 |
| clk_slow_i | input | 1 | Slow source clock, chosen when select is 0 |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_fast_i | input | 1 | Source select level, asynchronous to both clocks |
| oe_i | input | 1 | Output enable; 0 parks the output low |
| clk_o | output | 1 | Switched clock output |

## Verification
A shutdown of one path and a start of the other can fall inside the same changeover window. This happens when the select flips back while the first changeover is still running, or when the output-enable drops during a switch. The bench provokes these cases with rapid toggles of the select and the enable at random spacing. It judges them two ways. First, it compares against a reference model that counts falling edges in each domain. Second, it measures the width of every output pulse against the faster half period.

// File: rtl/clksw_pkg.sv
`timescale 1ps/1ps
package clksw_pkg;
  localparam int unsigned SRC_CNT  = 2;
  localparam int unsigned SRC_SLOW = 0;
  localparam int unsigned SRC_FAST = 1;
endpackage

// File: rtl/clksw_rst_sync.sv
`timescale 1ps/1ps
module clksw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[LAST];

  // R1
  rst_hold_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    rst_no |=> rst_no);
endmodule

// File: rtl/clksw_path.sv
`timescale 1ps/1ps
module clksw_path #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic other_busy_i,
  input  logic other_en_i,
  output logic busy_o,
  output logic en_o,
  output logic gclk_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic          rst_loc_n;
  logic          req;
  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;

  clksw_rst_sync #(.STAGES(STAGES)) i_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_loc_n)
  );

  // request only while the other side is fully idle (all stages clear)
  always_comb begin
    req    = want_i & ~other_busy_i;
    sync_d = {sync_q[LAST-1:0], req};
  end

  // falling-edge chain: enable moves only while this clock is low
  always_ff @(negedge clk_i or negedge rst_loc_n) begin
    if (!rst_loc_n) sync_q <= '0;
    else            sync_q <= sync_d;
  end

  assign en_o   = sync_q[LAST];
  assign busy_o = |sync_q;
  assign gclk_o = clk_i & en_o;

  // R5
  excl_chk: assert property (@(negedge clk_i) disable iff (!rst_loc_n)
    en_o |-> !other_en_i);

  if (STAGES == 2) begin : g_chk
    // R4
    park_chk: assert property (@(negedge clk_i) disable iff (!rst_loc_n)
      $past(!want_i, 2) |-> !en_o);

    // R5
    start_chk: assert property (@(negedge clk_i) disable iff (!rst_loc_n)
      ($past(rst_loc_n, 2) && $past(want_i, 2) && !$past(other_busy_i, 2)) |-> en_o);
  end
endmodule

// File: rtl/hpsafe_clk_switch.sv
`timescale 1ps/1ps
module hpsafe_clk_switch
  import clksw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_fast_i,
  input  logic clk_slow_i,
  input  logic rst_ni,
  input  logic sel_fast_i,
  input  logic oe_i,
  output logic clk_o
);
  logic [SRC_CNT-1:0] src_clk;
  logic [SRC_CNT-1:0] want;
  logic [SRC_CNT-1:0] busy;
  logic [SRC_CNT-1:0] en;
  logic [SRC_CNT-1:0] gclk;

  assign src_clk[SRC_FAST] = clk_fast_i;
  assign src_clk[SRC_SLOW] = clk_slow_i;
  assign want[SRC_FAST]    = sel_fast_i & oe_i;
  assign want[SRC_SLOW]    = ~sel_fast_i & oe_i;

  for (genvar g = 0; g < SRC_CNT; g++) begin : g_path
    clksw_path #(.STAGES(SYNC_STAGES)) i_path (
      .clk_i        (src_clk[g]),
      .rst_ni       (rst_ni),
      .want_i       (want[g]),
      .other_busy_i (busy[SRC_CNT-1-g]),
      .other_en_i   (en[SRC_CNT-1-g]),
      .busy_o       (busy[g]),
      .en_o         (en[g]),
      .gclk_o       (gclk[g])
    );
  end

  assign clk_o = |gclk;
endmodule

// File: tb/test_hpsafe_clk_switch.sv
`timescale 1ps/1ps
module test_hpsafe_clk_switch;
  localparam int HALF_F = 13564;  // fast source half period, ps
  localparam int HALF_S = 14764;  // slow source half period, ps

  logic clk = 1'b0;
  logic clk_f = 1'b0;
  logic clk_s = 1'b0;
  logic rst_n, sel, oe;
  logic clk_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  hpsafe_clk_switch i_hpsafe_clk_switch (
    .clk_fast_i (clk_f),
    .clk_slow_i (clk_s),
    .rst_ni     (rst_n),
    .sel_fast_i (sel),
    .oe_i       (oe),
    .clk_o      (clk_o)
  );

  // edges: bench on multiples of 4 ps, fast at 1 mod 4, slow at 3 mod 4
  always #10000 clk = ~clk;
  initial begin #1; forever #(HALF_F) clk_f = ~clk_f; end
  initial begin #3; forever #(HALF_S) clk_s = ~clk_s; end

  // behavioural model: per-domain edge counters and staged decisions
  int cnt_f = 0, cnt_s = 0;
  bit st_f = 0, en_f = 0, st_s = 0, en_s = 0;

  always @(negedge rst_n) begin
    cnt_f = 0; cnt_s = 0; st_f = 0; en_f = 0; st_s = 0; en_s = 0;
  end

  always @(negedge clk_f) begin
    if (!rst_n) begin cnt_f = 0; st_f = 0; en_f = 0; end
    else begin
      cnt_f++;
      if (cnt_f >= 3) begin
        en_f = st_f;
        st_f = (sel && oe) && !(st_s || en_s);
      end
    end
  end

  always @(negedge clk_s) begin
    if (!rst_n) begin cnt_s = 0; st_s = 0; en_s = 0; end
    else begin
      cnt_s++;
      if (cnt_s >= 3) begin
        en_s = st_s;
        st_s = (!sel && oe) && !(st_f || en_f);
      end
    end
  end

  // compare on every bench clock
  always @(negedge clk) begin
    logic exp_o;
    exp_o = (clk_f & en_f) | (clk_s & en_s);
    if (!done) begin
      checks++;
      if (clk_o !== exp_o) begin
        fails++;
        $display("FAIL %s: clk_o=%b expected %b at %0t", cur_req, clk_o, exp_o, $time);
      end
    end
  end

  // R6 pulse-width monitor
  longint last_edge = 0;
  bit armed = 0;
  always @(clk_o) begin
    if (rst_n === 1'b1 && !done) begin
      if (armed) begin
        checks++;
        if (($time - last_edge) < HALF_F) begin
          fails++;
          $display("FAIL R6: pulse width %0d ps expected >= %0d ps", $time - last_edge, HALF_F);
        end
      end
      armed = 1'b1;
    end
    last_edge = $time;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0; sel = 1'b1; oe = 1'b1;
    cur_req = "R1";
    wait_cyc(6);
    rst_n = 1'b1;
    wait_cyc(30);
    cur_req = "R2";
    wait_cyc(60);
    sel = 1'b0;
    cur_req = "R4";
    wait_cyc(6);
    cur_req = "R5";
    wait_cyc(10);
    cur_req = "R3";
    wait_cyc(60);
    cur_req = "R8";
    for (int i = 0; i < 120; i++) begin
      sel = ~sel;
      wait_cyc($urandom_range(1, 12));
    end
    wait_cyc(20);
    cur_req = "R7";
    oe = 1'b0;
    wait_cyc(40);
    oe = 1'b1;
    wait_cyc(20);
    for (int i = 0; i < 40; i++) begin
      if ($urandom_range(0, 1) == 0) oe = ~oe; else sel = ~sel;
      wait_cyc($urandom_range(1, 10));
    end
    oe = 1'b1;
    wait_cyc(30);
    cur_req = "R1";
    rst_n = 1'b0;
    wait_cyc(3);
    checks++;
    if (clk_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: clk_o=%b expected 0 in reset", clk_o);
    end
    rst_n = 1'b1;
    wait_cyc(30);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_cyc(150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule